// File: doc/BRIEF.md
# Bank-Aware Memory Request Reorder Scheduler

This block sits in front of a memory controller that has sixteen interleaved banks. Several requesters send it read and write requests. The block keeps them in a small queue and picks one request per cycle to send to memory. The pick depends on three things: how old each request is, whether its bank is idle, and whether it is a read or a write. Reads go first as a rule. A younger request to an idle bank may overtake an older one that is stuck on a busy bank. Once a write has been sent, further writes keep going for a short burst, which saves bus turnarounds.

Memory may finish reads in any order. Each read stays in its queue entry with its data until every earlier read from the same requester has been delivered. Each requester therefore sees its read data in the order it asked for it. The memory takes one issued request per cycle and never pushes back. Writes leave the queue as soon as they are issued. Reads leave when their data is delivered.

Top module: `mem_reorder_sched`

## Requirements
- R1: After an active-low reset the queue is empty, `req_ready` is 1, `iss_valid` is 0 and every bit of `rsp_valid` is 0.
- R2: The queue holds DEPTH (8) requests. `req_ready` is 0 when all entries are taken, and a request offered while `req_ready` is 0 is not accepted.
- R3: A request's bank is `addr[3:0]`. No request is issued while `bank_busy` is set for its bank.
- R4: Among candidates of the chosen kind, the oldest is issued. A younger request to an idle bank is issued ahead of an older request whose bank is busy.
- R5: Requests to the same bank are issued in the order they arrived.
- R6: When no write burst is running and both a read and a write are eligible, the read is issued.
- R7: A write issue starts a burst. While fewer than BURST (4) consecutive writes have been issued, an eligible write is chosen over an eligible read. After the fourth write, an eligible read is issued next.
- R8: A read to the same address as an older queued write is not issued before that write.
- R9: Completions carry the issue tag (`iss_tag`). Read data is delivered on `rsp_valid[r]`/`rsp_data` slice r in the order requester r issued its reads, however memory orders the completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has a free entry |
| req_id | input | $clog2(NREQ) | Requester number |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address; low bits select the bank |
| req_wdata | input | DW | Write data |
| bank_busy | input | NBANK | One bit per bank, 1 = bank cannot accept |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_wr | output | 1 | Issued request is a write |
| iss_addr | output | AW | Issued address |
| iss_wdata | output | DW | Issued write data |
| iss_tag | output | $clog2(DEPTH) | Queue entry of the issued request |
| cpl_valid | input | 1 | Read completion from memory |
| cpl_tag | input | $clog2(DEPTH) | Entry the completion belongs to |
| cpl_data | input | DW | Read data |
| rsp_valid | output | NREQ | Per-requester delivery strobe |
| rsp_data | output | NREQ*DW | Per-requester read data, DW bits each |

## Verification
The bench uses the default parameters: four requesters, an eight-entry queue, sixteen banks and a write burst limit of four. With these values, eight requests entered while all banks are held busy fill the queue. Releasing the banks then shows the whole issue order at once: read priority, blocking within a bank, the write burst that keeps priority over a newly eligible read, and the same-address hazard. A second pattern of five writes and one read to a held bank reaches the burst limit, so the read is seen to regain priority exactly after the fourth write. Completions are returned out of order across two requesters so that the return buffering decides the delivery order.

// File: rtl/mem_reorder_sched.sv
module mem_reorder_sched #(
  parameter int NREQ  = 4,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int NBANK = 16,
  parameter int BURST = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(NREQ)-1:0]    req_id,
  input  logic                       req_wr,
  input  logic [AW-1:0]              req_addr,
  input  logic [DW-1:0]              req_wdata,
  input  logic [NBANK-1:0]           bank_busy,
  output logic                       iss_valid,
  output logic                       iss_wr,
  output logic [AW-1:0]              iss_addr,
  output logic [DW-1:0]              iss_wdata,
  output logic [$clog2(DEPTH)-1:0]   iss_tag,
  input  logic                       cpl_valid,
  input  logic [$clog2(DEPTH)-1:0]   cpl_tag,
  input  logic [DW-1:0]              cpl_data,
  output logic [NREQ-1:0]            rsp_valid,
  output logic [NREQ*DW-1:0]         rsp_data
);
  localparam int IDW = $clog2(NREQ);
  localparam int QW  = $clog2(DEPTH);
  localparam int BW  = $clog2(NBANK);
  localparam int SW  = QW + 1;
  localparam int CW  = $clog2(BURST + 1);
  localparam int OW  = QW + 1;
  localparam logic [1:0] S_FREE = 2'd0, S_PEND = 2'd1, S_WAIT = 2'd2, S_DONE = 2'd3;

  logic [1:0]       st     [DEPTH];
  logic [IDW-1:0]   e_id   [DEPTH];
  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [SW-1:0]    e_seq  [DEPTH];
  logic [DEPTH-1:0] elder  [DEPTH];  // elder[i][j]: entry j arrived before entry i
  logic [DEPTH-1:0] e_wr;
  logic [SW-1:0]    wseq   [NREQ];
  logic [SW-1:0]    nseq   [NREQ];
  logic [CW-1:0]    wcnt;

  logic [DEPTH-1:0] fr, pend, elig, rd_el, wr_el, cand;
  logic [QW-1:0]    alloc, pick;
  logic             found, use_wr, burst_on;
  logic [NREQ-1:0]  dl;
  logic [QW-1:0]    dl_idx [NREQ];

  always_comb begin
    alloc = '0;
    found = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      fr[i]   = st[i] == S_FREE;
      pend[i] = st[i] == S_PEND;
      if (st[i] == S_FREE) begin
        alloc = QW'(i);
        found = 1'b1;
      end
    end
  end
  assign req_ready = found;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = pend[i] && !bank_busy[e_addr[i][BW-1:0]];
      for (int j = 0; j < DEPTH; j++)
        if (pend[j] && elder[i][j] && e_addr[j][BW-1:0] == e_addr[i][BW-1:0])
          elig[i] = 1'b0;
    end
  end

  assign rd_el    = elig & ~e_wr;
  assign wr_el    = elig & e_wr;
  assign burst_on = (wcnt != '0) && (wcnt != CW'(BURST));
  assign use_wr   = |wr_el && (burst_on || !(|rd_el));
  assign cand     = use_wr ? wr_el : rd_el;

  always_comb begin
    pick = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cand[i] && !(|(cand & elder[i]))) pick = QW'(i);
  end

  assign iss_valid = |cand;
  assign iss_wr    = use_wr;
  assign iss_addr  = e_addr[pick];
  assign iss_wdata = e_data[pick];
  assign iss_tag   = pick;

  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      dl[r]     = 1'b0;
      dl_idx[r] = '0;
      for (int i = 0; i < DEPTH; i++)
        if (st[i] == S_DONE && e_id[i] == IDW'(r) && e_seq[i] == nseq[r]) begin
          dl[r]     = 1'b1;
          dl_idx[r] = QW'(i);
        end
      rsp_data[r*DW +: DW] = e_data[dl_idx[r]];
    end
  end
  assign rsp_valid = dl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i]    <= S_FREE;
        elder[i] <= '0;
      end
      for (int r = 0; r < NREQ; r++) begin
        wseq[r] <= '0;
        nseq[r] <= '0;
      end
      wcnt <= '0;
    end else begin
      if (req_valid && found) begin
        st[alloc]     <= S_PEND;
        e_id[alloc]   <= req_id;
        e_wr[alloc]   <= req_wr;
        e_addr[alloc] <= req_addr;
        e_data[alloc] <= req_wdata;
        e_seq[alloc]  <= wseq[req_id];
        for (int i = 0; i < DEPTH; i++) elder[i][alloc] <= 1'b0;
        elder[alloc] <= ~fr;
        if (!req_wr) wseq[req_id] <= wseq[req_id] + 1'b1;
      end
      if (|cand) begin
        st[pick] <= use_wr ? S_FREE : S_WAIT;
        wcnt     <= use_wr ? ((wcnt == CW'(BURST)) ? CW'(1) : wcnt + 1'b1) : '0;
      end
      if (cpl_valid) begin
        st[cpl_tag]     <= S_DONE;
        e_data[cpl_tag] <= cpl_data;
      end
      for (int r = 0; r < NREQ; r++)
        if (dl[r]) begin
          st[dl_idx[r]] <= S_FREE;
          nseq[r]       <= nseq[r] + 1'b1;
        end
    end
  end

  logic [CW:0] wrun;
  logic [OW-1:0] occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrun <= '0;
      occ  <= '0;
    end else begin
      if (iss_valid && !iss_wr) wrun <= '0;
      else if (iss_valid && iss_wr && |rd_el) wrun <= wrun + 1'b1;
      occ <= occ + OW'(req_valid && req_ready) - OW'(iss_valid && iss_wr)
                 - OW'($countones(rsp_valid));
    end
  end

  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !bank_busy[iss_addr[BW-1:0]]); // R3
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_wr && |rd_el |-> wrun < (CW+1)'(BURST)); // R7
  AST_CPL_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> st[cpl_tag] == S_WAIT); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH)); // R2
  AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> occ == OW'(DEPTH)); // R2
endmodule

// File: tb/mem_reorder_sched_bench.sv
module mem_reorder_sched_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, cpl_valid = 1'b0;
  logic [1:0] req_id = '0;
  logic [15:0] req_addr = '0, req_wdata = '0, cpl_data = '0;
  logic [15:0] bank_busy = '1;
  logic [2:0] cpl_tag = '0;
  logic req_ready, iss_valid, iss_wr;
  logic [15:0] iss_addr, iss_wdata;
  logic [2:0] iss_tag;
  logic [3:0] rsp_valid;
  logic [63:0] rsp_data;

  mem_reorder_sched u_mem_reorder_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_busy(bank_busy), .iss_valid(iss_valid), .iss_wr(iss_wr),
    .iss_addr(iss_addr), .iss_wdata(iss_wdata), .iss_tag(iss_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  always #4 clk = ~clk;

  int total = 0, bad = 0, nlog = 0;
  logic [15:0] lg_addr [32];
  logic [15:0] lg_wd   [32];
  logic        lg_wr   [32];
  logic [2:0]  lg_tag  [32];
  logic [15:0] rs_data [4][16];
  int          rcnt    [4] = '{0, 0, 0, 0};

  always @(negedge clk) if (rst_n) begin
    if (iss_valid && nlog < 32) begin
      lg_addr[nlog] = iss_addr; lg_wd[nlog] = iss_wdata;
      lg_wr[nlog] = iss_wr;     lg_tag[nlog] = iss_tag;
      nlog++;
    end
    for (int r = 0; r < 4; r++)
      if (rsp_valid[r] && rcnt[r] < 16) begin
        rs_data[r][rcnt[r]] = rsp_data[r*16 +: 16];
        rcnt[r]++;
      end
  end

  // {wr, requester, addr[11:0], expected issue rank}
  localparam logic [17:0] TBL [8] = '{
    {1'b1, 2'd3, 12'h011, 3'd3},
    {1'b0, 2'd0, 12'h022, 3'd0},
    {1'b0, 2'd0, 12'h032, 3'd1},
    {1'b1, 2'd3, 12'h043, 3'd4},
    {1'b0, 2'd1, 12'h055, 3'd2},
    {1'b1, 2'd3, 12'h061, 3'd5},
    {1'b0, 2'd1, 12'h061, 3'd7},
    {1'b1, 2'd3, 12'h087, 3'd6}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic enq(input logic [1:0] id, input logic wr, input logic [15:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_id = id; req_wr = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic cpl(input logic [2:0] t, input logic [15:0] d);
    cpl_valid = 1'b1; cpl_tag = t; cpl_data = d;
    @(posedge clk); #1;
    cpl_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog got=timeout exp=completion");
    finish_run();
  end

  initial begin
    int base;
    logic [2:0] tg [8];
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 no issue after reset", {31'd0, iss_valid}, 32'd0);
    chk("R1 no response after reset", {28'd0, rsp_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // table: fill the queue with every bank held busy
    for (int i = 0; i < 8; i++)
      enq(TBL[i][16:15], TBL[i][17], {4'h0, TBL[i][14:3]}, 16'hD000 + 16'(i));
    @(negedge clk);
    chk("R2 ready low when full", {31'd0, req_ready}, 32'd0);
    chk("R3 nothing issued to busy banks", nlog, 0);
    @(posedge clk); #1;
    enq(2'd2, 1'b0, 16'h0F0F, 16'h0);   // offered while full
    bank_busy = '0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R2 extra request not accepted", nlog, 8);
    chk("R2 ready back after writes leave", {31'd0, req_ready}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      int rk;
      rk = int'(TBL[i][2:0]);
      chk("R4/R6 table issue address", {16'd0, lg_addr[rk]}, {20'd0, TBL[i][14:3]});
      chk("R4/R6 table issue kind", {31'd0, lg_wr[rk]}, {31'd0, TBL[i][17]});
      if (TBL[i][17]) chk("R4 issued write data", {16'd0, lg_wd[rk]}, 32'hD000 + 32'(i));
      tg[i] = lg_tag[rk];
    end
    chk("R5 same bank first read", {16'd0, lg_addr[0]}, 32'h022);
    chk("R5 same bank second read", {16'd0, lg_addr[1]}, 32'h032);
    chk("R8 read after same-address write", {31'd0, lg_wr[7]}, 32'd0);
    chk("R7 burst write over newly eligible read", {16'd0, lg_addr[6]}, 32'h087);

    // out-of-order completions
    @(posedge clk); #1;
    cpl(tg[2], 16'hA002);
    cpl(tg[6], 16'hA006);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 requester0 held back", rcnt[0], 0);
    chk("R9 requester1 held back", rcnt[1], 0);
    @(posedge clk); #1;
    cpl(tg[1], 16'hA001);
    cpl(tg[4], 16'hA004);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 requester0 count", rcnt[0], 2);
    chk("R9 requester1 count", rcnt[1], 2);
    chk("R9 requester0 first", {16'd0, rs_data[0][0]}, 32'hA001);
    chk("R9 requester0 second", {16'd0, rs_data[0][1]}, 32'hA002);
    chk("R9 requester1 first", {16'd0, rs_data[1][0]}, 32'hA004);
    chk("R9 requester1 second", {16'd0, rs_data[1][1]}, 32'hA006);

    // write burst limit
    @(posedge clk); #1;
    bank_busy = '1;
    base = nlog;
    enq(2'd2, 1'b0, 16'h0100, 16'h0);
    for (int k = 1; k <= 5; k++) enq(2'd3, 1'b1, 16'h0100 + 16'(k), 16'hE000 + 16'(k));
    bank_busy = 16'h0001;
    wait (nlog == base + 1);
    @(posedge clk); #1;
    bank_busy = '0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R4 younger idle-bank write before busy-bank read", {16'd0, lg_addr[base]}, 32'h101);
    chk("R7 burst write two", {16'd0, lg_addr[base+1]}, 32'h102);
    chk("R7 burst write three", {16'd0, lg_addr[base+2]}, 32'h103);
    chk("R7 burst write four", {16'd0, lg_addr[base+3]}, 32'h104);
    chk("R7 read after four writes", {15'd0, lg_wr[base+4], lg_addr[base+4]}, 32'h100);
    chk("R6 remaining write last", {15'd0, lg_wr[base+5], lg_addr[base+5]}, 32'h1_0105);
    @(posedge clk); #1;
    cpl(lg_tag[base+4], 16'hBEEF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 requester2 count", rcnt[2], 1);
    chk("R9 requester2 data", {16'd0, rs_data[2][0]}, 32'hBEEF);
    finish_run();
  end
endmodule